// File: doc/BRIEF.md
# Compare/PWM Interval Timer

This block is an 8-bit up-counter with two 8-bit compare values, A and B, and an 8-bit control word. The counter advances on a tick that a free-running prescaler derives from the system clock. In normal mode, compare A is the only compare value that matters. A match on A can return the counter to zero and can change one output line: toggle it, drive it low or drive it high. In PWM mode, compare B sets the top of the count, so the period can be shorter than 256 ticks. Compare A sets the point where the output falls.

Software reaches the block through a single-cycle register port. The port has a write strobe, an address and write data, and a read mux that returns the addressed register in the same cycle. This port is control traffic only. It has no valid/ready handshake, and every write takes effect on the clock edge where `reg_we` is high. The output line reaches the pin only while the external enable input is high. A sticky flag records every compare-A match.

Top module: `tmr_cmp_pwm`

## Requirements
- R1: After reset, every register reads 0x00, the counter is stopped, the flag is 0 and `pin_o` is 0.
- R2: The clock-select field is control bits 3:0. Code 0 stops the counter. Code k (1..15) advances it once every 2^(k-1) clocks, paced by a prescaler that runs from reset onward.
- R3: The clear-on-match enable is control bit 7. In normal mode with this bit set, a tick that finds the counter equal to compare A loads 0x00 instead of counting up.
- R4: In normal mode with clear-on-match off, the counter counts through the compare-A value and wraps from 0xFF to 0x00. Compare B has no effect in normal mode.
- R5: The output-action field is control bits 5:4, and it acts on each compare-A match tick in normal mode. 01 toggles the line, 10 drives it low and 11 drives it high. 00 leaves the line state unchanged and holds `pin_o` at 0.
- R6: PWM mode is control bit 6. In PWM mode, a tick that finds the counter at or above compare B loads 0x00. The clear-on-match bit is ignored in this mode.
- R7: In PWM mode, the line goes high on the tick where the counter restarts at 0x00. It goes low on a compare-A match tick. Restart wins when both happen on the same tick, so compare A at or above compare B keeps the line high. The line reaches the pin regardless of the action field.
- R8: `pin_o` is 0 whenever `pin_oe_i` is 0, and otherwise shows the line state as R5/R7 allow.
- R9: Every compare-A match tick, in either mode, sets a sticky flag. The flag is shown on `cmpa_flag_o` and as bit 0 of address 4. Writing 1 to that bit clears it, writing 0 does nothing, and a match in the same cycle as a clear wins.
- R10: Register map: address 0 is control, 1 is counter, 2 is compare A, 3 is compare B and 4 is status. Addresses 0 to 3 read back what was written. Unused addresses read 0x00.
- R11: A write to the counter address loads the counter on that edge and takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pin_oe_i | input | 1 | External output enable for the compare line |
| pin_o | output | 1 | Compare/PWM line as seen at the pin |
| cmpa_flag_o | output | 1 | Sticky compare-A match flag |

## Verification
The bench pushes the counter onto the compare-A value with clear-on-match on and off, and checks every register and output against a behavioural model on every clock.
- If the clear came one tick late, the count would show one tick past the match value.
- A design that let compare B act in normal mode would cut the wrap short of 0xFF.
- In PWM mode, the bench sets compare A below, equal to and above compare B, and also at zero. Giving the fall precedence over the restart would show a low line where the line should stay high.
- It also issues flag clears while matches keep arriving, and counter writes on tick cycles. These expose a clear that beats a set, and a tick that overrides a load.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_W  = 8;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    ACT_OFF    = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } act_e;

  typedef struct packed {
    logic             clr_on_a;
    logic             pwm_en;
    act_e             act;
    logic [SEL_W-1:0] sel;
  } ctrl_t;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned SEL_W = tmr_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = (1 << SEL_W) - 2;
  localparam logic [PRE_W-1:0] PRE_ONE = 1;
  localparam logic [SEL_W-1:0] SEL_ONE = 1;

  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] lim;

  // free-running divider, never reset by control writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + PRE_ONE;
  end

  // low (k-1) bits all ones -> one tick per 2^(k-1) clocks
  always_comb begin
    lim    = (PRE_ONE << (sel_i - SEL_ONE)) - PRE_ONE;
    tick_o = (sel_i != '0) && ((div_q & lim) == lim);
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned W = tmr_pkg::TMR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         pwm_i,
  input  logic         clr_on_a_i,
  input  logic [W-1:0] cmpa_i,
  input  logic [W-1:0] cmpb_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         match_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ONE = 1;
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_a, at_top;

  always_comb begin
    at_a    = (cnt_q == cmpa_i);
    at_top  = (cnt_q >= cmpb_i);
    match_o = tick_i && at_a;
    wrap_o  = tick_i && pwm_i && at_top;
    cnt_d   = cnt_q;
    if (load_i)                  cnt_d = load_val_i;
    else if (tick_i) begin
      if (pwm_i)                 cnt_d = at_top ? '0 : cnt_q + ONE;
      else if (clr_on_a_i && at_a) cnt_d = '0;
      else                       cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_clear_after_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !pwm_i && clr_on_a_i && cnt_q == cmpa_i && !load_i) |=> (cnt_q == '0));

  p_wrap_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !pwm_i && !clr_on_a_i && cnt_q == MAXV && !load_i) |=> (cnt_q == '0));

  p_pwm_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && pwm_i && cnt_q >= cmpb_i && !load_i) |=> (cnt_q == '0));

  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_i,
  input  tmr_pkg::act_e act_i,
  input  logic          match_i,
  input  logic          wrap_i,
  input  logic          oe_i,
  output logic          pin_o
);
  import tmr_pkg::*;

  logic line_q, line_d;

  always_comb begin
    line_d = line_q;
    if (pwm_i) begin
      if (wrap_i)       line_d = 1'b1;
      else if (match_i) line_d = 1'b0;
    end else if (match_i) begin
      case (act_i)
        ACT_TOGGLE: line_d = ~line_q;
        ACT_LOW:    line_d = 1'b0;
        ACT_HIGH:   line_d = 1'b1;
        default:    line_d = line_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end

  assign pin_o = oe_i && (pwm_i || act_i != ACT_OFF) && line_q;

  p_restart_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_i && wrap_i) |=> line_q);

  p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_i && act_i == ACT_OFF) |=> $stable(line_q));

  p_pin_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_i |-> !pin_o);
endmodule

// File: rtl/tmr_cmp_pwm.sv
module tmr_cmp_pwm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       pin_oe_i,
  output logic       pin_o,
  output logic       cmpa_flag_o
);
  import tmr_pkg::*;

  ctrl_t            ctrl_q;
  logic [TMR_W-1:0] cmpa_q, cmpb_q, cnt;
  logic             flag_q;
  logic             tick, match, wrap;
  logic             wr_ctrl, wr_cnt, wr_a, wr_b, clr_flag;

  always_comb begin
    wr_ctrl  = reg_we && reg_addr == A_CTRL;
    wr_cnt   = reg_we && reg_addr == A_CNT;
    wr_a     = reg_we && reg_addr == A_CMPA;
    wr_b     = reg_we && reg_addr == A_CMPB;
    clr_flag = reg_we && reg_addr == A_STAT && reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata);
      if (wr_a)    cmpa_q <= reg_wdata;
      if (wr_b)    cmpb_q <= reg_wdata;
    end
  end

  // set has precedence over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (match)    flag_q <= 1'b1;
    else if (clr_flag) flag_q <= 1'b0;
  end

  tmr_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (ctrl_q.sel),
    .tick_o (tick)
  );

  tmr_count #(.W(TMR_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .pwm_i      (ctrl_q.pwm_en),
    .clr_on_a_i (ctrl_q.clr_on_a),
    .cmpa_i     (cmpa_q),
    .cmpb_i     (cmpb_q),
    .load_i     (wr_cnt),
    .load_val_i (reg_wdata),
    .cnt_o      (cnt),
    .match_o    (match),
    .wrap_o     (wrap)
  );

  tmr_wave u_wave (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_i   (ctrl_q.pwm_en),
    .act_i   (ctrl_q.act),
    .match_i (match),
    .wrap_i  (wrap),
    .oe_i    (pin_oe_i),
    .pin_o   (pin_o)
  );

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_CNT:   reg_rdata = cnt;
      A_CMPA:  reg_rdata = cmpa_q;
      A_CMPB:  reg_rdata = cmpb_q;
      A_STAT:  reg_rdata = {7'b0, flag_q};
      default: reg_rdata = '0;
    endcase
  end

  assign cmpa_flag_o = flag_q;

  p_stopped_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.sel == '0 && !wr_cnt) |=> $stable(cnt));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_flag) |=> flag_q);

  p_flag_on_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q);
endmodule

// File: tb/tmr_cmp_pwm_test.sv
module tmr_cmp_pwm_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd1;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       pin_oe_i = 1'b1;
  logic       pin_o, cmpa_flag_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // behavioural model state
  int m_ctrl = 0, m_cnt = 0, m_a = 0, m_b = 0, m_flag = 0, m_line = 0, m_pre = 0;

  always #4 clk = ~clk;

  tmr_cmp_pwm uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_oe_i(pin_oe_i),
    .pin_o(pin_o), .cmpa_flag_o(cmpa_flag_o)
  );

  task automatic chk(input int act, input int exp, input string tag, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // model update on each rising edge, from stable inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_a = 0; m_b = 0; m_flag = 0; m_line = 0; m_pre = 0;
    end else begin
      int sel, pwm, clr, act, n_cnt, n_line, n_flag;
      bit tick, match, restart;
      sel = m_ctrl & 15; pwm = (m_ctrl >> 6) & 1; clr = (m_ctrl >> 7) & 1; act = (m_ctrl >> 4) & 3;
      tick = (sel != 0) && ((m_pre % (1 << (sel - 1))) == ((1 << (sel - 1)) - 1));
      match = tick && (m_cnt == m_a);
      restart = tick && pwm == 1 && (m_cnt >= m_b);
      n_cnt = m_cnt;
      if (reg_we && reg_addr == 1) n_cnt = reg_wdata;
      else if (tick) begin
        if (pwm == 1) n_cnt = (m_cnt >= m_b) ? 0 : m_cnt + 1;
        else if (clr == 1 && m_cnt == m_a) n_cnt = 0;
        else n_cnt = (m_cnt + 1) % 256;
      end
      n_line = m_line;
      if (pwm == 1) begin
        if (restart) n_line = 1;
        else if (match) n_line = 0;
      end else if (match) begin
        if (act == 1) n_line = 1 - m_line;
        else if (act == 2) n_line = 0;
        else if (act == 3) n_line = 1;
      end
      n_flag = m_flag;
      if (match) n_flag = 1;
      else if (reg_we && reg_addr == 4 && reg_wdata[0]) n_flag = 0;
      if (reg_we && reg_addr == 0) m_ctrl = reg_wdata;
      if (reg_we && reg_addr == 2) m_a = reg_wdata;
      if (reg_we && reg_addr == 3) m_b = reg_wdata;
      m_cnt = n_cnt; m_line = n_line; m_flag = n_flag;
      m_pre = (m_pre + 1) % 16384;
    end
  end

  // per-clock comparison, 2 ns after the edge
  always begin
    @(posedge clk);
    #2;
    if (rst_n && !done) begin
      int exp_rd, pwm, act;
      string ctag;
      pwm = (m_ctrl >> 6) & 1; act = (m_ctrl >> 4) & 3;
      ctag = (pwm == 1) ? "R6" : (((m_ctrl >> 7) & 1) == 1 ? "R3" : "R4");
      case (reg_addr)
        3'd0: exp_rd = m_ctrl;
        3'd1: exp_rd = m_cnt;
        3'd2: exp_rd = m_a;
        3'd3: exp_rd = m_b;
        3'd4: exp_rd = m_flag;
        default: exp_rd = 0;
      endcase
      chk(reg_rdata, exp_rd, (reg_addr == 1) ? ctag : "R10", "read data");
      chk(pin_o, (pin_oe_i && (pwm == 1 || act != 0) && m_line == 1) ? 1 : 0,
          (pwm == 1) ? "R7" : "R5", "pin");
      chk(cmpa_flag_o, m_flag, "R9", "flag");
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[2:0]; reg_wdata = d[7:0];
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd1;
  endtask

  task automatic expect_rd(input int a, input int exp, input string tag);
    @(negedge clk);
    reg_addr = a[2:0];
    @(posedge clk);
    #2;
    chk(reg_rdata, exp, tag, "directed read");
    @(negedge clk);
    reg_addr = 3'd1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) expect_rd(a, 0, "R1");
    chk(pin_o, 0, "R1", "pin after reset");
    // R10 map and readback
    wr(2, 8'h5A); wr(3, 8'h33);
    expect_rd(2, 8'h5A, "R10");
    expect_rd(3, 8'h33, "R10");
    expect_rd(6, 0, "R10");
    // R2 stopped and divided
    wr(1, 7); run(50);
    expect_rd(1, 7, "R2");
    wr(0, 8'h03); wr(1, 0);
    repeat (40) @(posedge clk);
    #2;
    chk(reg_rdata, 10, "R2", "count after 40 clocks at code 3");
    // R11 load
    wr(0, 8'h01); wr(1, 8'h40);
    chk(reg_rdata, 8'h40, "R11", "counter load");
    // R3 clear on match, toggle
    wr(2, 8'h20); wr(0, 8'h91); run(300);
    wr(0, 8'h92); run(300);
    // R4 / R5 wrap through match, B irrelevant
    wr(3, 8'h10); wr(0, 8'h21); run(600);
    wr(0, 8'h31); run(600);
    wr(0, 8'h11); run(600);
    wr(0, 8'h01); run(300);
    // R6 / R7 PWM
    wr(2, 8'h10); wr(3, 8'h40); wr(0, 8'h41); run(400);
    wr(2, 8'h50); run(300);
    wr(2, 8'h40); run(300);
    wr(2, 8'h00); run(200);
    wr(2, 8'h18); wr(0, 8'hC2); run(400);
    wr(3, 8'h08); run(100);
    // R8 enable gate
    wr(2, 8'h30); wr(3, 8'h60); wr(0, 8'h41);
    for (int i = 0; i < 200 && m_line == 0; i++) @(negedge clk);
    @(negedge clk);
    pin_oe_i = 1'b0;
    #1 chk(pin_o, 0, "R8", "pin with enable low");
    run(150);
    pin_oe_i = 1'b1;
    // R9 flag
    wr(0, 8'h00); wr(4, 1);
    expect_rd(4, 0, "R9");
    wr(2, 8'h20); wr(1, 8'h1F); wr(0, 8'h01); run(5);
    wr(0, 8'h00);
    expect_rd(4, 1, "R9");
    wr(4, 0);
    expect_rd(4, 1, "R9");
    wr(4, 1);
    expect_rd(4, 0, "R9");
    // clears while matches keep arriving
    wr(2, 8'h03); wr(3, 8'h03); wr(0, 8'h41);
    for (int i = 0; i < 12; i++) wr(4, 1);
    run(20);
    done = 1;
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule